// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block sits on the device side of a synchronous DRAM and handles the clock-enable pin. At every rising edge it samples the pin and registers the value. The registered copy is the qualify enable for the next edge. Every other piece of device logic advances only on edges where this enable is high. When the enable is low, commands are not decoded and latency counters stay where they are.

Alongside the enable, a small state machine tracks the power state. It has four states. RUN is normal operation. FROZEN means an operation is suspended in place. PDOWN is power-down. SREF is self-refresh. The choice of state is made on the edge where the pin is first seen low. That edge still executes normally, and the choice depends on bank idleness and on the command that arrives with the falling pin.

While in SREF, an internal counter takes a slow timer tick and produces a one-cycle refresh request at a programmable period. Burst terminate is accepted as a command code but behaves like NOP here.

The state machine has three transitions:
- HOLD, on a disabled edge.
- RESUME, on an enabled edge with the pin high.
- ENTER, on an enabled edge with the pin low.

Top module: `cke_power_ctrl`

## Requirements
- R1: `clk_qual_o` equals the value of `cke_i` sampled at the previous rising edge. Synchronous active-low reset sets it to 1.
- R2: On an edge where `clk_qual_o` is 0 (HOLD), `pstate_o` keeps its value whatever `cmd_i`, `cs_n_i` and `banks_idle_i` are.
- R3: On an edge where `clk_qual_o` is 1 and `cke_i` is 1 (RESUME), `pstate_o` becomes RUN (2'b00). A low-power state is therefore left on the first enabled edge after the pin is sampled high again.
- R4: ENTER (`clk_qual_o` 1, `cke_i` 0) with `banks_idle_i` 0 moves to FROZEN (2'b01), even if the command is auto refresh.
- R5: ENTER with `banks_idle_i` 1 and an effective command other than auto refresh moves to PDOWN (2'b10). This covers NOP 2'b00, burst terminate 2'b10 and other 2'b11.
- R6: ENTER with `banks_idle_i` 1 and effective command auto refresh (`cmd_i` 2'b01) moves to SREF (2'b11).
- R7: While `cs_n_i` is 1 the effective command is NOP, but `cke_i` is still honoured.
- R8: In SREF, a counter counts cycles with `sr_tick_i` high. `ref_req_o` is 1 for the one cycle after every `sr_period_i`-th tick, and a period of 0 acts as 1. The counter runs whether or not the enable is high.
- R9: The counter is held at zero outside SREF, and `ref_req_o` is 1 only in the cycle after an edge at which the state was SREF.
- R10: Reset places the block in RUN with `ref_req_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| cmd_i | input | 2 | Decoded command: 00 NOP, 01 auto refresh, 10 burst terminate, 11 other |
| banks_idle_i | input | 1 | All banks precharged and nothing in progress |
| sr_tick_i | input | 1 | Self-refresh timer tick |
| sr_period_i | input | SR_W | Ticks per internal refresh request |
| clk_qual_o | output | 1 | Qualify enable for all other device logic |
| pstate_o | output | 2 | Power state: 00 RUN, 01 FROZEN, 10 PDOWN, 11 SREF |
| ref_req_o | output | 1 | One-cycle internal refresh request |

## Verification
The hardest situation to reach from the ports is the single enabled edge on which a low-power state is left. On that one edge the pin can already be low again, so the machine must re-enter instead of staying in RUN. The stimulus produces it by raising `cke_i` for exactly one cycle while in PDOWN. It then lowers `cke_i` again and checks that `clk_qual_o` rose for a single cycle and that the state returned to PDOWN without passing through RUN. The refresh counter is checked by counting pulses over a fixed window of ticks, including the edge on which the state leaves SREF.

// File: rtl/ckepw_pkg.sv
package ckepw_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'b00,
        PS_FROZEN = 2'b01,
        PS_PDOWN  = 2'b10,
        PS_SREF   = 2'b11
    } pstate_t;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_AREF  = 2'b01,
        CMD_BSTOP = 2'b10,
        CMD_OTHER = 2'b11
    } cmd_t;

    typedef enum logic [1:0] {
        TR_HOLD   = 2'b00,
        TR_RESUME = 2'b01,
        TR_ENTER  = 2'b10
    } trans_t;

endpackage

// File: rtl/cke_sampler.sv
module cke_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_i,
    output logic qual_o
);
    logic qual_q;

    // Registered pin value: the enable for the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b1;
        else        qual_q <= cke_i;
    end

    assign qual_o = qual_q;
endmodule

// File: rtl/cke_entry_decode.sv
module cke_entry_decode
    import ckepw_pkg::*;
(
    input  logic    cs_n_i,
    input  logic    [1:0] cmd_i,
    input  logic    banks_idle_i,
    output pstate_t target_o
);
    cmd_t eff_cmd;

    // A deselected device sees NOP.
    always_comb begin
        eff_cmd = cs_n_i ? CMD_NOP : cmd_t'(cmd_i);
    end

    always_comb begin
        if (!banks_idle_i) begin
            target_o = PS_FROZEN;
        end else begin
            unique case (eff_cmd)
                CMD_AREF:  target_o = PS_SREF;
                CMD_NOP,
                CMD_BSTOP,
                CMD_OTHER: target_o = PS_PDOWN;
                default:   target_o = PS_PDOWN;
            endcase
        end
    end
endmodule

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
    import ckepw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    qual_i,
    input  logic    cke_i,
    input  pstate_t target_i,
    output logic    [1:0] pstate_o,
    output logic    in_sref_o
);
    pstate_t state_q, state_d;
    trans_t  trans;

    // Classify the edge.
    always_comb begin
        unique case ({qual_i, cke_i})
            2'b00, 2'b01: trans = TR_HOLD;
            2'b11:        trans = TR_RESUME;
            2'b10:        trans = TR_ENTER;
            default:      trans = TR_HOLD;
        endcase
    end

    always_comb begin
        unique case (trans)
            TR_HOLD:   state_d = state_q;
            TR_RESUME: state_d = PS_RUN;
            TR_ENTER:  state_d = target_i;
            default:   state_d = state_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        pstate_o  = state_q;
        in_sref_o = 1'b0;
        unique case (state_q)
            PS_RUN:    in_sref_o = 1'b0;
            PS_FROZEN: in_sref_o = 1'b0;
            PS_PDOWN:  in_sref_o = 1'b0;
            PS_SREF:   in_sref_o = 1'b1;
            default:   in_sref_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cke_sref_timer.sv
module cke_sref_timer #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_i,
    input  logic            tick_i,
    input  logic [SR_W-1:0] period_i,
    output logic            req_o
);
    localparam int CW = SR_W + 1;

    logic [SR_W-1:0] cnt_q;
    logic            req_q;
    logic            expire;

    // Expiry when this tick completes the period; period 0 behaves as 1.
    always_comb begin
        expire = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, period_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else if (tick_i) begin
            cnt_q <= expire ? '0 : cnt_q + SR_W'(1);
            req_q <= expire;
        end else begin
            req_q <= 1'b0;
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
    import ckepw_pkg::*;
#(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke_i,
    input  logic            cs_n_i,
    input  logic [1:0]      cmd_i,
    input  logic            banks_idle_i,
    input  logic            sr_tick_i,
    input  logic [SR_W-1:0] sr_period_i,
    output logic            clk_qual_o,
    output logic [1:0]      pstate_o,
    output logic            ref_req_o
);
    logic    qual;
    logic    in_sref;
    pstate_t target;

    cke_sampler u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke_i  (cke_i),
        .qual_o (qual)
    );

    cke_entry_decode u_dec (
        .cs_n_i       (cs_n_i),
        .cmd_i        (cmd_i),
        .banks_idle_i (banks_idle_i),
        .target_o     (target)
    );

    cke_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual_i    (qual),
        .cke_i     (cke_i),
        .target_i  (target),
        .pstate_o  (pstate_o),
        .in_sref_o (in_sref)
    );

    cke_sref_timer #(.SR_W(SR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (in_sref),
        .tick_i   (sr_tick_i),
        .period_i (sr_period_i),
        .req_o    (ref_req_o)
    );

    assign clk_qual_o = qual;
endmodule

// File: rtl/cke_power_chk.sv
module cke_power_chk #(
    parameter int SR_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cke_i,
    input logic            cs_n_i,
    input logic [1:0]      cmd_i,
    input logic            banks_idle_i,
    input logic            sr_tick_i,
    input logic [SR_W-1:0] sr_period_i,
    input logic            clk_qual_o,
    input logic [1:0]      pstate_o,
    input logic            ref_req_o
);
    logic pv;
    always_ff @(posedge clk) pv <= rst_n;

    a_r1_qual_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        pv |-> (clk_qual_o == $past(cke_i)));

    a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_qual_o |=> (pstate_o == $past(pstate_o)));

    a_r3_resume_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_qual_o && cke_i) |=> (pstate_o == 2'b00));

    a_r4_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_qual_o && !cke_i && !banks_idle_i) |=> (pstate_o == 2'b01));

    a_r6_sref_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_qual_o && !cke_i && banks_idle_i && !cs_n_i && cmd_i == 2'b01)
        |=> (pstate_o == 2'b11));

    a_r7_deselect_pdown: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_qual_o && !cke_i && banks_idle_i && cs_n_i) |=> (pstate_o == 2'b10));

    a_r9_req_only_in_sref: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && ref_req_o) |-> ($past(pstate_o) == 2'b11));

    a_r8_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !sr_tick_i) |=> !ref_req_o);
endmodule

bind cke_power_ctrl cke_power_chk #(.SR_W(SR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke_i        (cke_i),
    .cs_n_i       (cs_n_i),
    .cmd_i        (cmd_i),
    .banks_idle_i (banks_idle_i),
    .sr_tick_i    (sr_tick_i),
    .sr_period_i  (sr_period_i),
    .clk_qual_o   (clk_qual_o),
    .pstate_o     (pstate_o),
    .ref_req_o    (ref_req_o)
);

// File: tb/sim_cke_power_ctrl.sv
module sim_cke_power_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SR_W = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cke;
    logic            cs_n;
    logic [1:0]      cmd;
    logic            idle;
    logic            tick;
    logic [SR_W-1:0] period;
    logic            qual;
    logic [1:0]      pst;
    logic            req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cke_power_ctrl #(.SR_W(SR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .cmd_i(cmd),
        .banks_idle_i(idle), .sr_tick_i(tick), .sr_period_i(period),
        .clk_qual_o(qual), .pstate_o(pst), .ref_req_o(req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0; cke = 1; cs_n = 0; cmd = 2'b00; idle = 1; tick = 0; period = 8'd3;
        step(); step();
        rst_n = 1;
        check("R10 state", pst, 0);
        check("R10 qual", qual, 1);
        check("R10 req", req, 0);
        step();
        check("R3 run stays", pst, 0);
    endtask

    task automatic t_freeze();
        idle = 0; cke = 0; cmd = 2'b01;
        step();
        check("R1 qual low after pin low", qual, 0);
        check("R4 frozen", pst, 1);
        cke = 1;
        step();
        check("R1 qual back high", qual, 1);
        check("R3 still frozen on re-sample edge", pst, 1);
        step();
        check("R3 run on first enabled edge", pst, 0);
    endtask

    task automatic t_pdown();
        idle = 1; cke = 0; cmd = 2'b00;
        step();
        check("R5 pdown", pst, 2);
        idle = 0; cmd = 2'b01; cs_n = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R2 hold while disabled", pst, 2);
        end
        cke = 1; idle = 1; cmd = 2'b00;
        step();
        check("R1 qual pulse high", qual, 1);
        cke = 0; cmd = 2'b10;
        step();
        check("R3 re-entry at exit edge", pst, 2);
        check("R1 qual low again", qual, 0);
        cke = 1;
        step(); step();
        check("R3 run after exit", pst, 0);
    endtask

    task automatic t_deselect();
        idle = 1; cke = 0; cs_n = 1; cmd = 2'b01;
        step();
        check("R7 deselected AREF gives pdown", pst, 2);
        cs_n = 0; cmd = 2'b00; cke = 1;
        step(); step();
        check("R7 exit", pst, 0);
    endtask

    task automatic t_sref();
        int pulses = 0;
        period = 8'd3;
        tick = 1;
        step();
        check("R9 no req in run", req, 0);
        idle = 1; cke = 0; cs_n = 0; cmd = 2'b01;
        step();
        check("R6 sref", pst, 3);
        check("R9 counter clear on entry", req, 0);
        cmd = 2'b00;
        for (int i = 0; i < 9; i++) begin
            step();
            if (req) pulses++;
            if (i == 1) check("R8 no early req", req, 0);
            if (i == 2) check("R8 req on third tick", req, 1);
        end
        check("R8 pulses over nine ticks", pulses, 3);
        tick = 0; cke = 1;
        step();
        check("R8 pulse is one cycle", req, 0);
        tick = 1;
        step();
        check("R3 run after sref", pst, 0);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R9 no req outside sref", req, 0);
        end
        period = 8'd0; tick = 1; cke = 0; cmd = 2'b01;
        step();
        cmd = 2'b00;
        step();
        check("R8 period zero acts as one", req, 1);
        tick = 0; cke = 1;
        step(); step();
        check("R3 run", pst, 0);
    endtask

    initial begin
        t_reset();
        t_freeze();
        t_pdown();
        t_deselect();
        t_sref();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule